// File: doc/BRIEF.md
# DMA Stream Interrupt Flag Bank

This block collects event flags for the eight streams of a DMA controller. Each stream's engine raises single-cycle pulses for four events: transfer complete, transfer error, direct-mode error and FIFO error. Each pulse sets a sticky flag. The flags are packed into two 32-bit status words. Streams 0 to 3 share the low word and streams 4 to 7 share the high word.

Software reads the status words through a small word-addressed register port. It acknowledges flags by writing ones to two matching clear words, which use the same bit layout. Each stream also supplies four interrupt-enable inputs. The block drives one registered interrupt line per stream, asserted while any of that stream's enabled flags is set.

The slot position of a stream inside its word is irregular. Bit 1 of the stream index adds 16 and bit 0 adds 6, so a slot starts at bit 0, 6, 16 or 22. Both the read packing and the clear decoding follow this layout.

Top module: `dma_flag_bank`

## Requirements
- R1: After reset, all flags are clear, both status words read zero, and every interrupt output is low.
- R2: An event pulse on a stream sets its flag at the clock edge where the pulse is sampled. Word address 0 (byte offset 0x0) shows streams 0 to 3 and word address 1 (0x4) shows streams 4 to 7.
- R3: Inside a slot, transfer complete is bit 5, transfer error is bit 3, direct-mode error is bit 2 and FIFO error is bit 0. The slot begins at bit (16 if index bit 1 is set) + (6 if index bit 0 is set).
- R4: A write to word address 2 (0x8, low) or 3 (0xC, high) clears every status flag whose bit is written 1. Bits written 0 leave their flags unchanged.
- R5: Writes to the status words change nothing, and the clear words always read zero.
- R6: Slot bits 1 and 4 and word bits 12 to 15 and 28 to 31 always read zero.
- R7: When an event and a clear write hit the same flag in the same cycle, the flag ends set.
- R8: Interrupt line s goes high one cycle after any flag of stream s is set while its enable input is high, and it goes low one cycle after no enabled flag remains.
- R9: A set flag stays set, with no further events, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_tc_i | input | 8 | Transfer-complete event pulse per stream |
| evt_te_i | input | 8 | Transfer-error event pulse per stream |
| evt_dme_i | input | 8 | Direct-mode-error event pulse per stream |
| evt_fe_i | input | 8 | FIFO-error event pulse per stream |
| ien_tc_i | input | 8 | Transfer-complete interrupt enable per stream |
| ien_te_i | input | 8 | Transfer-error interrupt enable per stream |
| ien_dme_i | input | 8 | Direct-mode-error interrupt enable per stream |
| ien_fe_i | input | 8 | FIFO-error interrupt enable per stream |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 2 | Word address: 0 status low, 1 status high, 2 clear low, 3 clear high |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word (combinational) |
| irq_o | output | 8 | Registered interrupt per stream |

## Verification
The embedded assertions check the per-flag rules on every cycle: an event always leaves its flag set, a clear without an event drops the flag, an untouched flag holds, reserved read bits are zero, the clear words read zero, and the interrupt follows the enabled flags one cycle later. Only the bench scenarios can show that the irregular slot offsets and the low/high word split land each stream's flags where the layout demands. The same holds for clear masks that reach exactly one flag of one stream, and for writes to status words and zero-valued clear writes being ignored.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int NUM_STREAMS = 8;
  localparam int WORD_W      = 32;
  localparam int SLOT_W      = 6;
  localparam int PER_WORD    = 4;
  localparam int NUM_KINDS   = 4;

  // kind index inside the compact flag vector
  localparam int K_FE  = 0;
  localparam int K_DME = 1;
  localparam int K_TE  = 2;
  localparam int K_TC  = 3;

  // used read bits of one slot: 5,3,2,0
  localparam logic [SLOT_W-1:0] SLOT_USED = 6'b101101;

  function automatic int slot_lsb(input int s);
    return (((s & 2) != 0) ? 16 : 0) + (((s & 1) != 0) ? 6 : 0);
  endfunction

  function automatic logic [WORD_W-1:0] word_used_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int s = 0; s < PER_WORD; s++) m[slot_lsb(s) +: SLOT_W] = SLOT_USED;
    return m;
  endfunction
endpackage

// File: rtl/dma_flag_slot.sv
module dma_flag_slot
  import dma_flag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_KINDS-1:0] set_i,
  input  logic [SLOT_W-1:0]    clr_i,
  input  logic [NUM_KINDS-1:0] en_i,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 irq_o
);
  logic [NUM_KINDS-1:0] flag_q;
  logic [NUM_KINDS-1:0] clr_k;
  logic                 unused_clr;

  assign clr_k      = {clr_i[5], clr_i[3], clr_i[2], clr_i[0]};
  assign unused_clr = clr_i[1] ^ clr_i[4];

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_k) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(flag_q & en_i);
  end

  assign slot_o = {flag_q[K_TC], 1'b0, flag_q[K_TE], flag_q[K_DME], 1'b0, flag_q[K_FE]};

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_chk
    p_evt_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_q[k]);
    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[k] && clr_k[k]) |=> flag_q[k]);
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_k[k] && !set_i[k]) |=> !flag_q[k]);
    p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && !clr_k[k]) |=> flag_q[k]);
    p_irq_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[k] && en_i[k]) |=> irq_o);
  end
  p_irq_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_q & en_i)) |=> !irq_o);
endmodule

// File: rtl/dma_flag_regif.sv
module dma_flag_regif
  import dma_flag_pkg::*;
(
  input  logic                                rst_ni,
  input  logic                                req_i,
  input  logic                                we_i,
  input  logic [1:0]                          addr_i,
  input  logic [WORD_W-1:0]                   wdata_i,
  input  logic [NUM_STREAMS-1:0][SLOT_W-1:0]  slot_i,
  output logic [NUM_STREAMS-1:0][SLOT_W-1:0]  clr_o,
  output logic [WORD_W-1:0]                   rdata_o
);
  localparam int NUM_WORDS = NUM_STREAMS / PER_WORD;
  localparam logic [WORD_W-1:0] USED = word_used_mask();

  logic [NUM_WORDS-1:0][WORD_W-1:0] stat_w;
  logic [NUM_WORDS-1:0][WORD_W-1:0] clr_w;
  logic                             unused_wdata;

  // addr[1] selects clear words, addr[0] selects high half
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign clr_w[w] = (req_i && we_i && addr_i[1] && (addr_i[0] == w[0])) ? wdata_i : '0;
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_slot
    localparam int LSB = slot_lsb(s);
    localparam int WI  = s / PER_WORD;
    assign clr_o[s] = clr_w[WI][LSB +: SLOT_W];
  end

  always_comb begin
    stat_w = '0;
    for (int s = 0; s < NUM_STREAMS; s++)
      stat_w[s / PER_WORD][slot_lsb(s) +: SLOT_W] = slot_i[s] & SLOT_USED;
  end

  assign rdata_o      = addr_i[1] ? '0 : stat_w[addr_i[0]];
  assign unused_wdata = ^(wdata_i & ~USED);

  always_comb begin
    if (rst_ni) begin
      p_reserved_zero_r6: assert ((rdata_o & ~USED) == '0);
      if (addr_i[1]) p_clr_reads_zero_r5: assert (rdata_o == '0);
    end
  end
endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        evt_tc_i,
  input  logic [7:0]        evt_te_i,
  input  logic [7:0]        evt_dme_i,
  input  logic [7:0]        evt_fe_i,
  input  logic [7:0]        ien_tc_i,
  input  logic [7:0]        ien_te_i,
  input  logic [7:0]        ien_dme_i,
  input  logic [7:0]        ien_fe_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [7:0]        irq_o
);
  logic [NUM_STREAMS-1:0][SLOT_W-1:0] slot_w;
  logic [NUM_STREAMS-1:0][SLOT_W-1:0] clr_w;

  dma_flag_regif u_regif (
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .slot_i  (slot_w),
    .clr_o   (clr_w),
    .rdata_o (rdata_o)
  );

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
    logic [NUM_KINDS-1:0] set_s, en_s;
    assign set_s = {evt_tc_i[s], evt_te_i[s], evt_dme_i[s], evt_fe_i[s]};
    assign en_s  = {ien_tc_i[s], ien_te_i[s], ien_dme_i[s], ien_fe_i[s]};

    dma_flag_slot u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_s),
      .clr_i  (clr_w[s]),
      .en_i   (en_s),
      .slot_o (slot_w[s]),
      .irq_o  (irq_o[s])
    );
  end
endmodule

// File: tb/dma_flag_bank_tb.sv
`timescale 1ns/1ps
module dma_flag_bank_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] evt_tc = '0, evt_te = '0, evt_dme = '0, evt_fe = '0;
  logic [7:0] en_tc = '0, en_te = '0, en_dme = '0, en_fe = '0;
  logic req = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0] irq;

  always #2 clk = ~clk;

  dma_flag_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .evt_tc_i(evt_tc), .evt_te_i(evt_te), .evt_dme_i(evt_dme), .evt_fe_i(evt_fe),
    .ien_tc_i(en_tc), .ien_te_i(en_te), .ien_dme_i(en_dme), .ien_fe_i(en_fe),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t sb_q[$];
  int n_chk = 0, n_err = 0;
  bit probe = 1'b0, done = 1'b0;
  logic [31:0] exp_lo = '0, exp_hi = '0;

  localparam int TC = 5, TE = 3, DME = 2, FE = 0;

  function automatic logic [31:0] mk(int s, int bitpos);
    int lsb;
    lsb = (((s & 2) != 0) ? 16 : 0) + (((s & 1) != 0) ? 6 : 0);
    return 32'h1 << (lsb + bitpos);
  endfunction

  // monitor: pops the scoreboard and compares at the falling edge
  always @(negedge clk) begin : mon
    item_t it;
    logic [31:0] act;
    if (probe && sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = it.is_irq ? {24'h0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_read(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it); probe = 1'b1;
    @(posedge clk); #1;
    req = 1'b0; probe = 1'b0;
  endtask

  task automatic exp_irq(input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1'b1; it.exp = {24'h0, e}; it.tag = tag;
    sb_q.push_back(it); probe = 1'b1;
    @(posedge clk); #1;
    probe = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input int s, input bit tc, input bit te, input bit dme, input bit fe);
    @(posedge clk); #1;
    evt_tc[s] = tc; evt_te[s] = te; evt_dme[s] = dme; evt_fe[s] = fe;
    @(posedge clk); #1;
    evt_tc = '0; evt_te = '0; evt_dme = '0; evt_fe = '0;
  endtask

  initial begin : watchdog
    #(4 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : drv
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    exp_read(2'd0, 32'h0, "R1 status low after reset");
    exp_read(2'd1, 32'h0, "R1 status high after reset");
    exp_irq(8'h00, "R1 irq after reset");

    // R2 single event lands in low word
    pulse(0, 1, 0, 0, 0);
    exp_read(2'd0, mk(0, TC), "R2 stream0 complete flag");
    wr(2'd2, 32'hffff_ffff);
    exp_read(2'd0, 32'h0, "R4 clear all low");

    // R3 / R6 every stream, every kind
    for (int s = 0; s < 8; s++) begin
      logic [31:0] m;
      m = mk(s, TC) | mk(s, TE) | mk(s, DME) | mk(s, FE);
      pulse(s, 1, 1, 1, 1);
      if (s < 4) begin
        exp_lo |= m;
        exp_read(2'd0, exp_lo, "R3 low slot placement");
      end else begin
        exp_hi |= m;
        exp_read(2'd1, exp_hi, "R3 high slot placement");
      end
    end
    exp_read(2'd0, 32'h0B6D_0B6D, "R6 low word reserved bits");
    exp_read(2'd1, 32'h0B6D_0B6D, "R6 high word reserved bits");

    // R5 status words ignore writes, clear words read zero
    wr(2'd0, 32'hffff_ffff);
    wr(2'd1, 32'h0);
    exp_read(2'd0, exp_lo, "R5 status low write ignored");
    exp_read(2'd1, exp_hi, "R5 status high write ignored");
    exp_read(2'd2, 32'h0, "R5 clear low reads zero");
    exp_read(2'd3, 32'h0, "R5 clear high reads zero");

    // R4 zero write no effect, single-bit clear
    wr(2'd2, 32'h0);
    exp_read(2'd0, exp_lo, "R4 zero clear no effect");
    wr(2'd2, mk(1, TC));
    exp_lo &= ~mk(1, TC);
    exp_read(2'd0, exp_lo, "R4 clear stream1 complete only");
    wr(2'd3, mk(6, FE) | mk(7, DME));
    exp_hi &= ~(mk(6, FE) | mk(7, DME));
    exp_read(2'd1, exp_hi, "R4 clear two high bits");
    wr(2'd3, 32'hffff_ffff);
    exp_hi = '0;
    exp_read(2'd1, 32'h0, "R4 clear all high");

    // R7 set wins over simultaneous clear
    @(posedge clk); #1;
    evt_te[5] = 1'b1;
    req = 1'b1; we = 1'b1; addr = 2'd3; wdata = mk(5, TE);
    @(posedge clk); #1;
    evt_te = '0; req = 1'b0; we = 1'b0; wdata = '0;
    exp_read(2'd1, mk(5, TE), "R7 set wins");
    repeat (5) @(posedge clk);
    exp_read(2'd1, mk(5, TE), "R9 flag holds");
    wr(2'd3, mk(5, TE));
    exp_read(2'd1, 32'h0, "R4 clear after set-wins");

    // R8 interrupt gating
    wr(2'd2, 32'hffff_ffff);
    exp_irq(8'h00, "R8 no flags no irq");
    en_tc[2] = 1'b1;
    pulse(2, 1, 0, 0, 0);
    exp_irq(8'h04, "R8 stream2 complete enabled");
    en_tc[3] = 1'b1;
    pulse(3, 0, 1, 0, 0);
    exp_irq(8'h04, "R8 stream3 error masked");
    en_fe[6] = 1'b1;
    pulse(6, 0, 0, 0, 1);
    exp_irq(8'h44, "R8 stream6 fifo error");
    en_dme[7] = 1'b1;
    pulse(7, 0, 0, 1, 0);
    exp_irq(8'hC4, "R8 stream7 direct-mode error");
    wr(2'd2, mk(2, TC));
    exp_irq(8'hC0, "R8 irq drops after clear");
    @(posedge clk); #1 en_fe[6] = 1'b0;
    exp_irq(8'h80, "R8 irq drops when enable removed");
    @(posedge clk); #1 en_te[3] = 1'b1;
    exp_irq(8'h88, "R9 R8 held flag raises irq on enable");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule